// File: doc/BRIEF.md
# Segment Descriptor Access Checker

This block keeps one 64-bit memory segment descriptor in a register, loaded through a write port. It checks each memory access request against that descriptor. A request carries a 32-bit offset, an access kind and the requester's current privilege level (CPL). The block unpacks the split base and limit fields and scales the limit when the granularity flag is set. It then checks presence, descriptor class, privilege, access rights and the bound.

One cycle after each request it returns one of two results: a 3-bit fault code, or the linear address (base plus offset). Only the highest-priority fault is reported. An address generation stage can place this block between its offset adder and the memory port. It converts segment-relative offsets into flat addresses and turns illegal accesses into fault codes for the exception logic.

Top module: `seg_access_checker`

## Requirements
- R1: After reset the response outputs are zero (`rsp_valid`, `rsp_fault` and `rsp_linear` all 0), and the held descriptor is all zeros, so the first access after reset reports the null fault.
- R2: When `desc_we` is high at a rising edge, `desc_wdata` becomes the held descriptor. A request in the same cycle as a write is still checked against the previous descriptor.
- R3: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and low otherwise.
- R4: The base is built from descriptor bits 39:16 (low 24 bits) and 63:56 (high 8 bits). The raw 20-bit limit is built from bits 15:0 (low) and 51:48 (high). With no fault, `rsp_linear` equals base plus offset modulo 2^32. With any fault, `rsp_linear` is 0.
- R5: A descriptor whose 64 bits are all zero gives fault code 1 (null) on any access.
- R6: If bit 47 (present) is 0, the access gives fault code 2.
- R7: If bit 44 is 0 (system descriptor), the access gives fault code 3.
- R8: The descriptor privilege level is bits 46:45. A CPL numerically greater than it gives fault code 4.
- R9: Access kinds are encoded 0 = read, 1 = write, 2 = fetch, and 3 is reserved. Bit 43 set means a code segment. For code, fetch is allowed, read is allowed only if bit 41 is set, and write is never allowed. For data, read is allowed, write is allowed only if bit 41 is set, and fetch is never allowed. Kind 3 is always denied. Any denial gives fault code 5.
- R10: A data segment with bit 42 set (expand-down) gives fault code 6, because it is unsupported. On a code segment, bit 42 has no effect on the result.
- R11: With bit 55 clear, the effective limit is the raw limit. With bit 55 set, it is the raw limit shifted left by 12 with the low 12 bits set to one. An offset above the effective limit gives fault code 7.
- R12: When several faults apply, the code reported is the first in this order: null, not present, system, privilege, rights, expand-down, bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_we | input | 1 | Load `desc_wdata` into the descriptor register |
| desc_wdata | input | 64 | Packed descriptor to load |
| req_valid | input | 1 | Access request present this cycle |
| req_offset | input | 32 | Segment-relative byte offset |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 reserved |
| req_cpl | input | 2 | Current privilege level of the requester |
| rsp_valid | output | 1 | Result of the previous cycle's request |
| rsp_fault | output | 3 | Fault code, 0 when the access is allowed |
| rsp_linear | output | 32 | Linear address, 0 when a fault is reported |

## Verification
Every decoded field reaches the ports one cycle after a request. A wrong bit position in the base or limit shows up as a wrong linear address or as a bound fault at the wrong offset. The most telling stimulus is offsets just around the effective limit, combined with base values near the top of the address space. A stale descriptor register shows up in the first response after a load. Swapping two steps of the fault priority only shows when several faults apply at once. The bench therefore builds descriptors with several defects combined and compares every response against a reference model.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

   localparam int DESC_W  = 64;
   localparam int BASE_W  = 32;
   localparam int LIMIT_W = 20;
   localparam int DPL_W   = 2;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_kind_e;

   typedef enum logic [2:0] {
      FLT_NONE    = 3'd0,
      FLT_NULL    = 3'd1,
      FLT_ABSENT  = 3'd2,
      FLT_SYSTEM  = 3'd3,
      FLT_PRIV    = 3'd4,
      FLT_RIGHTS  = 3'd5,
      FLT_EXPDOWN = 3'd6,
      FLT_BOUND   = 3'd7
   } fault_e;

   typedef struct packed {
      logic              is_null;
      logic [BASE_W-1:0] base;
      logic [LIMIT_W-1:0] limit;
      logic              gran;
      logic              present;
      logic [DPL_W-1:0]  dpl;
      logic              is_cs;     // code/data class (not system)
      logic              is_code;
      logic              dir_conf;  // expand-down (data) / conforming (code)
      logic              rw;        // writable (data) / readable (code)
   } desc_fields_t;

endpackage

// File: rtl/seg_desc_store.sv
module seg_desc_store
   import seg_chk_pkg::*;
#(
   parameter int D_W = DESC_W
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           we,
   input  logic [D_W-1:0] wdata,
   output logic [D_W-1:0] raw,
   output desc_fields_t   fields
);

   initial begin
      assert (D_W == 64) else $error("seg_desc_store: descriptor must be 64 bits");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  raw <= '0;
      else if (we) raw <= wdata;
   end

   always_comb begin
      fields.is_null  = (raw == '0);
      fields.base     = {raw[63:56], raw[39:16]};
      fields.limit    = {raw[51:48], raw[15:0]};
      fields.gran     = raw[55];
      fields.present  = raw[47];
      fields.dpl      = raw[46:45];
      fields.is_cs    = raw[44];
      fields.is_code  = raw[43];
      fields.dir_conf = raw[42];
      fields.rw       = raw[41];
   end

   // R2: a write lands in the register at the edge it is sampled
   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> raw == $past(wdata));

endmodule

// File: rtl/seg_limit_scale.sv
module seg_limit_scale #(
   parameter int LIM_W      = 20,
   parameter int ADDR_W     = 32,
   parameter int GRAN_SHIFT = 12
) (
   input  logic [LIM_W-1:0]  limit,
   input  logic              gran,
   output logic [ADDR_W-1:0] eff_limit
);

   localparam int SCALED_W = LIM_W + GRAN_SHIFT;

   initial begin
      assert (ADDR_W > LIM_W) else $error("seg_limit_scale: address narrower than limit");
      assert (GRAN_SHIFT > 0) else $error("seg_limit_scale: shift must be positive");
   end

   logic [SCALED_W-1:0] scaled;
   logic [ADDR_W-1:0]   page_lim;
   logic [ADDR_W-1:0]   byte_lim;

   assign scaled   = {limit, {GRAN_SHIFT{1'b1}}};
   assign byte_lim = {{(ADDR_W-LIM_W){1'b0}}, limit};

   generate
      if (SCALED_W >= ADDR_W) begin : g_trunc
         assign page_lim = scaled[ADDR_W-1:0];
      end else begin : g_extend
         assign page_lim = {{(ADDR_W-SCALED_W){1'b0}}, scaled};
      end
   endgenerate

   assign eff_limit = gran ? page_lim : byte_lim;

endmodule

// File: rtl/seg_fault_eval.sv
module seg_fault_eval
   import seg_chk_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  desc_fields_t      f,
   input  logic [ADDR_W-1:0] eff_limit,
   input  logic [ADDR_W-1:0] offset,
   input  acc_kind_e         kind,
   input  logic [DPL_W-1:0]  cpl,
   output fault_e            fault
);

   logic rights_ok;

   always_comb begin
      unique case (kind)
         ACC_READ:  rights_ok = !f.is_code || f.rw;
         ACC_WRITE: rights_ok = !f.is_code && f.rw;
         ACC_FETCH: rights_ok = f.is_code;
         default:   rights_ok = 1'b0;
      endcase
   end

   always_comb begin
      if (f.is_null)                    fault = FLT_NULL;
      else if (!f.present)              fault = FLT_ABSENT;
      else if (!f.is_cs)                fault = FLT_SYSTEM;
      else if (cpl > f.dpl)             fault = FLT_PRIV;
      else if (!rights_ok)              fault = FLT_RIGHTS;
      else if (!f.is_code && f.dir_conf) fault = FLT_EXPDOWN;
      else if (offset > eff_limit)      fault = FLT_BOUND;
      else                              fault = FLT_NONE;
   end

endmodule

// File: rtl/seg_access_checker.sv
module seg_access_checker
   import seg_chk_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int GRAN_SHIFT = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              desc_we,
   input  logic [63:0]       desc_wdata,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_offset,
   input  logic [1:0]        req_kind,
   input  logic [1:0]        req_cpl,
   output logic              rsp_valid,
   output logic [2:0]        rsp_fault,
   output logic [ADDR_W-1:0] rsp_linear
);

   initial begin
      assert (ADDR_W == BASE_W) else $error("seg_access_checker: address width must match base");
      assert (LIMIT_W + GRAN_SHIFT == ADDR_W) else $error("seg_access_checker: scaled limit must span the address");
   end

   logic [63:0]       desc_raw;
   desc_fields_t      fld;
   logic [ADDR_W-1:0] eff_limit;
   logic [ADDR_W-1:0] lin_sum;
   fault_e            flt;

   seg_desc_store #(.D_W(64)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (desc_we),
      .wdata  (desc_wdata),
      .raw    (desc_raw),
      .fields (fld)
   );

   seg_limit_scale #(.LIM_W(LIMIT_W), .ADDR_W(ADDR_W), .GRAN_SHIFT(GRAN_SHIFT)) u_lim (
      .limit     (fld.limit),
      .gran      (fld.gran),
      .eff_limit (eff_limit)
   );

   seg_fault_eval #(.ADDR_W(ADDR_W)) u_eval (
      .f         (fld),
      .eff_limit (eff_limit),
      .offset    (req_offset),
      .kind      (acc_kind_e'(req_kind)),
      .cpl       (req_cpl),
      .fault     (flt)
   );

   assign lin_sum = fld.base + req_offset;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_fault  <= 3'd0;
         rsp_linear <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_fault  <= flt;
            rsp_linear <= (flt == FLT_NONE) ? lin_sum : '0;
         end
      end
   end

   p_rsp_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_rsp_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   p_fault_no_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != 3'd0) |-> rsp_linear == '0);
   p_null_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && desc_raw == 64'd0) |=> rsp_fault == 3'd1);
   p_priv_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && desc_raw[47] && desc_raw[44] && req_cpl > desc_raw[46:45]) |=> rsp_fault == 3'd4);
   p_in_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && flt == FLT_NONE) |=> ($past(req_offset) <= $past(eff_limit)));

endmodule

// File: tb/seg_access_checker_bench.sv
module seg_access_checker_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        desc_we = 1'b0;
   logic [63:0] desc_wdata = '0;
   logic        req_valid = 1'b0;
   logic [31:0] req_offset = '0;
   logic [1:0]  req_kind = '0;
   logic [1:0]  req_cpl = '0;
   logic        rsp_valid;
   logic [2:0]  rsp_fault;
   logic [31:0] rsp_linear;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;
   logic [63:0] cur_desc = '0;

   always #5 clk = ~clk;

   seg_access_checker u_seg_access_checker (
      .clk(clk), .rst_n(rst_n), .desc_we(desc_we), .desc_wdata(desc_wdata),
      .req_valid(req_valid), .req_offset(req_offset), .req_kind(req_kind),
      .req_cpl(req_cpl), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
      .rsp_linear(rsp_linear));

   function automatic logic [63:0] mk_desc(input logic [31:0] base, input logic [19:0] lim,
      input logic g, input logic p, input logic s, input logic [1:0] dpl,
      input logic code, input logic dc, input logic rw);
      logic [63:0] d;
      d = '0;
      d[15:0] = lim[15:0];   d[51:48] = lim[19:16];
      d[39:16] = base[23:0]; d[63:56] = base[31:24];
      d[41] = rw; d[42] = dc; d[43] = code; d[44] = s;
      d[46:45] = dpl; d[47] = p; d[54] = 1'b1; d[55] = g;
      return d;
   endfunction

   // reference model: {fault, linear}
   function automatic logic [34:0] model(input logic [63:0] d, input logic [31:0] off,
      input logic [1:0] kind, input logic [1:0] cpl);
      logic [31:0] base, lim;
      logic code, ok;
      base = {d[63:56], d[39:16]};
      lim  = d[55] ? {d[51:48], d[15:0], 12'hFFF} : {12'h0, d[51:48], d[15:0]};
      code = d[43];
      case (kind)
         2'd0: ok = !code || d[41];
         2'd1: ok = !code && d[41];
         2'd2: ok = code;
         default: ok = 1'b0;
      endcase
      if (d == 64'd0)            return {3'd1, 32'd0};
      if (!d[47])                return {3'd2, 32'd0};
      if (!d[44])                return {3'd3, 32'd0};
      if (cpl > d[46:45])        return {3'd4, 32'd0};
      if (!ok)                   return {3'd5, 32'd0};
      if (!code && d[42])        return {3'd6, 32'd0};
      if (off > lim)             return {3'd7, 32'd0};
      return {3'd0, base + off};
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic load(input logic [63:0] d);
      @(negedge clk);
      desc_we = 1'b1; desc_wdata = d;
      @(negedge clk);
      desc_we = 1'b0;
      cur_desc = d;
   endtask

   task automatic access(input string req, input logic [31:0] off, input logic [1:0] kind,
      input logic [1:0] cpl);
      logic [34:0] e;
      e = model(cur_desc, off, kind, cpl);
      @(negedge clk);
      req_valid = 1'b1; req_offset = off; req_kind = kind; req_cpl = cpl;
      @(negedge clk);
      req_valid = 1'b0;
      check({req, " R3 valid"}, 64'(rsp_valid), 64'd1);
      check({req, " fault"}, 64'(rsp_fault), 64'(e[34:32]));
      check({req, " linear R4"}, 64'(rsp_linear), 64'(e[31:0]));
      @(negedge clk);
      check("R3 idle", 64'(rsp_valid), 64'd0);
   endtask

   function automatic logic [31:0] near(input logic [63:0] d);
      logic [31:0] lim;
      lim = d[55] ? {d[51:48], d[15:0], 12'hFFF} : {12'h0, d[51:48], d[15:0]};
      case ($urandom % 4)
         0: return lim;
         1: return lim + 32'd1;
         2: return lim - ($urandom % 16);
         default: return $urandom;
      endcase
   endfunction

   initial begin
      void'($urandom(32'h1234_5EED));
      repeat (3) @(negedge clk);
      check("R1 valid", 64'(rsp_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 fault", 64'(rsp_fault), 64'd0);
      check("R1 linear", 64'(rsp_linear), 64'd0);
      access("R1 R5 null after reset", 32'h10, 2'd0, 2'd0);

      // flat 4 GiB kernel code
      load(mk_desc(32'h0, 20'hFFFFF, 1, 1, 1, 2'd0, 1, 0, 1));
      access("R11 flat top", 32'hFFFF_FFFF, 2'd2, 2'd0);
      access("R9 code write", 32'h0, 2'd1, 2'd0);
      access("R8 user on kernel", 32'h0, 2'd2, 2'd3);
      // byte granular data at 1 MiB
      load(mk_desc(32'h0010_0000, 20'h00FFF, 0, 1, 1, 2'd3, 0, 0, 1));
      access("R11 byte last", 32'h0000_0FFF, 2'd1, 2'd3);
      access("R11 byte over", 32'h0000_1000, 2'd0, 2'd3);
      access("R9 data fetch", 32'h0, 2'd2, 2'd3);
      access("R9 reserved kind", 32'h0, 2'd3, 2'd0);
      // wrapping base
      load(mk_desc(32'hFFFF_F000, 20'hFFFFF, 1, 1, 1, 2'd0, 0, 0, 0));
      access("R4 wrap", 32'h0000_2000, 2'd0, 2'd0);
      access("R9 read-only write", 32'h0, 2'd1, 2'd0);
      // combined defects
      load(mk_desc(32'h0, 20'h0, 0, 0, 0, 2'd0, 0, 0, 0));
      access("R6 R12 absent over system", 32'h5, 2'd2, 2'd3);
      load(mk_desc(32'h0, 20'h0, 0, 1, 0, 2'd0, 0, 0, 0));
      access("R7 R12 system over priv", 32'h5, 2'd2, 2'd3);
      load(mk_desc(32'h0, 20'h0, 0, 1, 1, 2'd1, 0, 1, 0));
      access("R8 R12 priv over rights", 32'h5, 2'd1, 2'd2);
      access("R10 R12 expdown over bound", 32'h5, 2'd0, 2'd1);
      load(mk_desc(32'h4000, 20'h0, 0, 1, 1, 2'd0, 1, 1, 0));
      access("R10 conforming ignored", 32'h0, 2'd2, 2'd0);
      access("R9 exec-only read", 32'h0, 2'd0, 2'd0);

      // R2: write and request in the same cycle use the old descriptor
      begin
         logic [34:0] e;
         logic [63:0] nd;
         nd = mk_desc(32'h8000_0000, 20'hFFFFF, 1, 1, 1, 2'd3, 0, 0, 1);
         e = model(cur_desc, 32'h0, 2'd2, 2'd0);
         @(negedge clk);
         desc_we = 1'b1; desc_wdata = nd;
         req_valid = 1'b1; req_offset = 32'h0; req_kind = 2'd2; req_cpl = 2'd0;
         @(negedge clk);
         desc_we = 1'b0; req_valid = 1'b0;
         cur_desc = nd;
         check("R2 same-cycle fault", 64'(rsp_fault), 64'(e[34:32]));
         check("R2 same-cycle linear", 64'(rsp_linear), 64'(e[31:0]));
         access("R2 new descriptor", 32'h123, 2'd1, 2'd3);
      end

      for (int i = 0; i < 400; i++) begin
         logic [63:0] d;
         d = mk_desc($urandom, 20'($urandom), 1'($urandom),
                     ($urandom % 8) != 0, ($urandom % 8) != 0, 2'($urandom),
                     1'($urandom), ($urandom % 4) == 0, 1'($urandom));
         if (($urandom % 32) == 0) d = '0;
         load(d);
         access("R12 random", near(d), 2'($urandom % 3), 2'($urandom));
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule